// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

A streaming convolutional encoder with constraint length 7 and code rate one half. Each accepted information bit is combined with the six bits received before it, and the encoder returns two coded bits for it. Each coded bit is the XOR of the taps that one of two fixed generator polynomials selects, 133 and 171 in octal. The encoder runs on an unbroken stream. It also runs on finite blocks: a flush request appends six zero tail bits, which return the 64-state trellis to the all-zero state.

Input and output use valid/ready handshakes. The coded pair is formed in the same cycle as the bit it encodes, so the input handshake passes straight through to the output. While the tail runs the input side is closed and the encoder drives the tail pairs by itself. A one-cycle completion pulse follows the last tail pair.

Top module: `conv_enc_r12`

## Requirements
- R1: After reset the memory is all zero, `out_valid_o` and `done_o` are low while no input is offered, and `in_ready_o` equals `out_ready_i`.
- R2: `out_sym_o[0]` is the XOR of the 7-bit window masked with 133 octal. Window bit 6 is the current bit, bit 5 the bit one step earlier, and so on down to bit 0, the bit six steps earlier.
- R3: `out_sym_o[1]` is the XOR of the same window masked with 171 octal.
- R4: In data mode, with no flush, `out_valid_o` follows `in_valid_i` and `in_ready_o` follows `out_ready_i` in the same cycle. Back-to-back bits are taken without bubbles, one coded pair per accepted bit.
- R5: A cycle without `in_valid_i` produces no output and leaves the memory unchanged.
- R6: While `out_ready_i` is low, `in_ready_o` is low, the memory holds and the offered pair stays the same.
- R7: When `flush_i` is high at a clock edge in data mode, no input bit is taken in that cycle. Over the following handshaken cycles six tail pairs are emitted for zero inputs, with `out_valid_o` high and `in_ready_o` low.
- R8: `done_o` is high for exactly the one cycle after the sixth tail pair is handshaken. The memory is zero at that time and data mode resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Information bit offered |
| in_bit_i | input | 1 | Information bit |
| in_ready_o | output | 1 | Bit accepted when high together with in_valid_i |
| flush_i | input | 1 | Request zero-tail termination |
| out_valid_o | output | 1 | Coded pair available |
| out_sym_o | output | 2 | Coded pair: bit 0 from 133, bit 1 from 171 |
| out_ready_i | input | 1 | Downstream accepts the coded pair |
| done_o | output | 1 | One-cycle pulse after the last tail pair |

## Verification
The bench builds the encoder with its default constants: constraint length 7, a six-bit memory, a tail length of six and the two generators. A six-step tail completes a block within a few cycles, so flush, backpressure inside the tail and the completion pulse can all be reached in short directed sequences. Two impulse-response vectors are worked out by hand and check each generator's tap positions one by one. A stream with gaps and stalls is checked against a model taken from the tap rules.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
  localparam int unsigned K_LEN   = 7;
  localparam int unsigned MEM_W   = K_LEN - 1;
  localparam int unsigned NUM_OUT = 2;
  // index 0 -> 133 octal, index 1 -> 171 octal; bit K_LEN-1 taps the current bit
  localparam logic [NUM_OUT-1:0][K_LEN-1:0] GEN_POLY = {7'o171, 7'o133};
endpackage

// File: rtl/cenc_parity.sv
module cenc_parity #(
  parameter int unsigned           WIN_W = 7,
  parameter logic [WIN_W-1:0]      POLY  = '1
) (
  input  logic [WIN_W-1:0] win_i,
  output logic             par_o
);
  assign par_o = ^(win_i & POLY);
endmodule

// File: rtl/cenc_shift_reg.sv
module cenc_shift_reg #(
  parameter int unsigned MEM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [MEM_W-1:0] state_o
);
  logic [MEM_W-1:0] state_q;

  // newest bit enters at the top, oldest leaves at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= '0;
    else if (en_i) state_q <= {bit_i, state_q[MEM_W-1:1]};
  end

  assign state_o = state_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));
endmodule

// File: rtl/cenc_tail_ctrl.sv
module cenc_tail_ctrl #(
  parameter int unsigned TAIL_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic step_i,
  output logic tail_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(TAIL_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TAIL_LEN - 1);

  logic             tail_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!tail_q) begin
        if (flush_i) begin
          tail_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (step_i) begin
        if (cnt_q == LAST) begin
          tail_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tail_o = tail_q;
  assign done_o = done_q;

  assert_tail_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tail_q) |-> $past(flush_i));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(tail_q));
endmodule

// File: rtl/conv_enc_r12.sv
module conv_enc_r12
  import cenc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic               in_bit_i,
  output logic               in_ready_o,
  input  logic               flush_i,
  output logic               out_valid_o,
  output logic [NUM_OUT-1:0] out_sym_o,
  input  logic               out_ready_i,
  output logic               done_o
);
  logic             tail_active, advance, data_fire, eff_bit;
  logic [MEM_W-1:0] state_q;
  logic [K_LEN-1:0] window;

  assign in_ready_o  = out_ready_i & ~tail_active & ~flush_i;
  assign data_fire   = in_valid_i & in_ready_o;
  assign out_valid_o = tail_active | (in_valid_i & ~flush_i);
  assign advance     = out_valid_o & out_ready_i;
  assign eff_bit     = tail_active ? 1'b0 : in_bit_i;
  assign window      = {eff_bit, state_q};

  cenc_shift_reg #(.MEM_W(MEM_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (advance),
    .bit_i  (eff_bit),
    .state_o(state_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_par
    cenc_parity #(.WIN_W(K_LEN), .POLY(GEN_POLY[g])) u_par (
      .win_i(window),
      .par_o(out_sym_o[g])
    );
  end

  cenc_tail_ctrl #(.TAIL_LEN(MEM_W)) u_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .step_i (tail_active & out_ready_i),
    .tail_o (tail_active),
    .done_o (done_o)
  );

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fire |=> state_q == {$past(in_bit_i), $past(state_q[MEM_W-1:1])});
  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(state_q));
  assert_no_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !tail_active) |-> !out_valid_o);
  assert_done_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_q == '0);
endmodule

// File: tb/conv_enc_r12_bench.sv
module conv_enc_r12_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_bit = 1'b0, flush = 1'b0, out_ready = 1'b0;
  logic       in_ready, out_valid, done;
  logic [1:0] out_sym;
  int         n_checks = 0, n_fail = 0;
  logic [5:0] m_st = '0;
  logic       finished = 1'b0;

  always #5 clk = ~clk;

  conv_enc_r12 u_conv_enc_r12 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_bit_i(in_bit),
    .in_ready_o(in_ready), .flush_i(flush), .out_valid_o(out_valid),
    .out_sym_o(out_sym), .out_ready_i(out_ready), .done_o(done)
  );

  // {input bit, expected {g171, g133}} from the zero state; impulse then a pair of ones
  localparam logic [2:0] VEC [15] = '{
    3'b1_11, 3'b0_10, 3'b0_11, 3'b0_11, 3'b0_00, 3'b0_01, 3'b0_11,
    3'b1_11, 3'b1_01, 3'b0_01, 3'b0_00, 3'b0_11, 3'b0_01, 3'b0_10, 3'b0_11
  };

  function automatic logic [1:0] ref_pair(logic b, logic [5:0] st);
    logic [6:0] w;
    w = {b, st};
    return {^(w & 7'o171), ^(w & 7'o133)};
  endfunction

  task automatic check(logic ok, string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic b, logic r, logic f);
    @(negedge clk);
    in_valid = v; in_bit = b; out_ready = r; flush = f;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(!out_valid, "R1 valid", 8'(out_valid), 8'd0);
    check(!done, "R1 done", 8'(done), 8'd0);
    check(in_ready, "R1 ready", 8'(in_ready), 8'd1);
    @(posedge clk);

    // R2 R3 hand-worked vectors from the zero state
    for (int i = 0; i < 15; i++) begin
      drive(1'b1, VEC[i][2], 1'b1, 1'b0);
      check(out_valid && in_ready, "R4 pass", {6'd0, out_valid, in_ready}, 8'd3);
      check(out_sym[0] == VEC[i][0], "R2 g133", 8'(out_sym[0]), 8'(VEC[i][0]));
      check(out_sym[1] == VEC[i][1], "R3 g171", 8'(out_sym[1]), 8'(VEC[i][1]));
      @(posedge clk);
    end
    m_st = '0;

    // R4 R5 R6 stream with gaps and stalls against the tap model
    for (int i = 0; i < 200; i++) begin
      logic v, b, r;
      v = ($urandom % 4) != 0;
      b = 1'($urandom);
      r = ($urandom % 5) != 0;
      drive(v, b, r, 1'b0);
      if (!v) begin
        check(!out_valid, "R5 idle", 8'(out_valid), 8'd0);
      end else begin
        check(out_sym == ref_pair(b, m_st), "R4 stream", 8'(out_sym), 8'(ref_pair(b, m_st)));
        check(in_ready == r, "R6 ready", 8'(in_ready), 8'(r));
        if (r) m_st = {b, m_st[5:1]};
      end
      @(posedge clk);
    end

    // R7 flush: bit offered in the flush cycle is not taken
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    check(!in_ready, "R7 flush ready", 8'(in_ready), 8'd0);
    @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      if (k == 2) begin
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check(out_valid && out_sym == ref_pair(1'b0, m_st), "R6 tail stall",
              8'(out_sym), 8'(ref_pair(1'b0, m_st)));
        @(posedge clk);
      end
      drive(1'b1, 1'b1, 1'b1, k == 3);
      check(out_valid && !in_ready, "R7 tail flags", {6'd0, out_valid, in_ready}, 8'd2);
      check(out_sym == ref_pair(1'b0, m_st), "R7 tail pair", 8'(out_sym), 8'(ref_pair(1'b0, m_st)));
      check(!done, "R8 early done", 8'(done), 8'd0);
      m_st = {1'b0, m_st[5:1]};
      @(posedge clk);
    end
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    check(done, "R8 done", 8'(done), 8'd1);
    check(in_ready, "R8 data mode", 8'(in_ready), 8'd1);
    @(posedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    check(!done, "R8 pulse", 8'(done), 8'd0);
    check(out_sym == 2'b11, "R8 zero state", 8'(out_sym), 8'd3);
    @(posedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    check(out_sym == 2'b10, "R8 zero state next", 8'(out_sym), 8'd2);
    @(posedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule